// File: doc/BRIEF.md
# Half-Cycle-Phase Divided Clock Generator

This block produces a forwarded serial clock for a high-speed data shifter. The clock period is a programmable whole number of fast-clock cycles, odd or even, and its starting phase can be placed in steps of half a fast-clock cycle. Every fast cycle the block outputs two bits: one for the first half of the cycle and one for the second. An external double-data-rate output stage drives them onto a pin, so the clock edges can fall at half-cycle positions.

Internally the generator tracks a position measured in half-cycles, modulo twice the period. The position moves forward only on cycles where the data shifter asserts its advance strobe, so the clock stays aligned to the data. While enable is low, the period is captured and the position is preset from the phase input. When enable rises again, the waveform restarts from that preset.

Top module: `hdclk_gen`

## Requirements
- R1: While reset is asserted, both `clk_p` and `clk_n` are 0.
- R2: A period code of 0 selects a period of 16 fast cycles; a code from 1 to 15 selects that many cycles.
- R3: Number the half-slots s = 0, 1, 2, ... from the first advancing cycle after enable rises, with two half-slots per advancing cycle. With period D and phase F, half-slot s is high exactly when ((s + F) mod 2D) >= D. In an advancing cycle covering half-slots s and s+1, `clk_p` carries slot s and `clk_n` carries slot s+1. This gives phase 0 a low start with the first rise D half-cycles after first data, for both odd and even D.
- R4: In a cycle with enable high and `adv` low, the half-slot position does not move. The next cycle repeats the same `clk_p`/`clk_n` pair.
- R5: While enable is low, the position is preset from `phase_in`. From the cycle after enable is seen low, the outputs show half-slots F and F+1 of the pattern, whatever the state of `adv`.
- R6: `period_in` and `phase_in` are taken only in cycles with enable low. Changing them while enable is high does not change the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds the generator at its preset phase |
| adv | input | 1 | Shifter advance strobe; the clock moves only when high |
| period_in | input | 4 | Period in fast cycles (0 means 16) |
| phase_in | input | 4 | Starting phase in half-cycles; must be below twice the period |
| clk_p | output | 1 | Clock value for the first half of the cycle |
| clk_n | output | 1 | Clock value for the second half of the cycle |

## Verification
On every cycle, the assertions check four things. The position stays below twice the period while running. The period is frozen while enabled. The position loads from the phase input while idle. The output pair holds across stalled cycles. Only the bench's scenarios can show the actual waveform: the exact half-slot pattern for every period from 1 to 16 and every legal phase, correct wrap-around with odd periods, and the period-code-0 case. The bench compares each output pair against a half-slot reference model under a pseudo-random stall pattern, with configuration changes made mid-run.

// File: rtl/hdclk_pkg.sv
package hdclk_pkg;

  // Map a period code to a cycle count; code 0 stands for the full range.
  function automatic int unsigned code_to_span(int unsigned code, int unsigned full);
    return (code == 0) ? full : code;
  endfunction

endpackage

// File: rtl/hdclk_cfg.sv
module hdclk_cfg #(
  parameter  int CFG_W  = 4,
  localparam int SLOT_W = CFG_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CFG_W-1:0]  period_in,
  output logic [SLOT_W-1:0] span
);
  import hdclk_pkg::*;

  logic [CFG_W-1:0] period_q;
  logic [CFG_W-1:0] period_d;

  // Capture only while the generator is idle.
  always_comb begin
    period_d = en ? period_q : period_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) period_q <= '0;
    else        period_q <= period_d;
  end

  always_comb begin
    span = SLOT_W'(code_to_span(int'(period_q), 1 << CFG_W));
  end
endmodule

// File: rtl/hdclk_slot_ctr.sv
module hdclk_slot_ctr #(
  parameter  int CFG_W  = 4,
  localparam int SLOT_W = CFG_W + 1,
  localparam int SUM_W  = SLOT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              adv,
  input  logic [CFG_W-1:0]  phase_in,
  input  logic [SLOT_W-1:0] span,
  output logic [SLOT_W-1:0] slot
);
  logic [SUM_W-1:0]  limit;
  logic [SUM_W-1:0]  raw_step;
  logic [SUM_W-1:0]  wrap_step;
  logic [SLOT_W-1:0] slot_d;

  always_comb begin
    limit    = {span, 1'b0};
    raw_step = {1'b0, slot} + SUM_W'(2);
    wrap_step = (raw_step >= limit) ? (raw_step - limit) : raw_step;
    if (!en)      slot_d = SLOT_W'(phase_in);
    else if (adv) slot_d = wrap_step[SLOT_W-1:0];
    else          slot_d = slot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot <= '0;
    else        slot <= slot_d;
  end
endmodule

// File: rtl/hdclk_slot_dec.sv
module hdclk_slot_dec #(
  parameter  int CFG_W  = 4,
  parameter  int LANES  = 2,
  localparam int SLOT_W = CFG_W + 1,
  localparam int SUM_W  = SLOT_W + 1
) (
  input  logic [SLOT_W-1:0] slot,
  input  logic [SLOT_W-1:0] span,
  output logic [LANES-1:0]  half_bits
);
  logic [SUM_W-1:0] limit;

  always_comb begin
    limit = {span, 1'b0};
  end

  // Lane k shows the half-slot k positions ahead of the current one.
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [SUM_W-1:0] raw_pos;
    logic [SUM_W-1:0] pos;
    always_comb begin
      raw_pos      = {1'b0, slot} + SUM_W'(k);
      pos          = (raw_pos >= limit) ? (raw_pos - limit) : raw_pos;
      half_bits[k] = (pos >= {1'b0, span});
    end
  end
endmodule

// File: rtl/hdclk_gen.sv
module hdclk_gen #(
  parameter  int CFG_W  = 4,
  localparam int SLOT_W = CFG_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             adv,
  input  logic [CFG_W-1:0] period_in,
  input  logic [CFG_W-1:0] phase_in,
  output logic             clk_p,
  output logic             clk_n
);
  logic [SLOT_W-1:0] span;
  logic [SLOT_W-1:0] slot;
  logic [1:0]        half_bits;

  hdclk_cfg #(.CFG_W(CFG_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .period_in (period_in),
    .span      (span)
  );

  hdclk_slot_ctr #(.CFG_W(CFG_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .adv      (adv),
    .phase_in (phase_in),
    .span     (span),
    .slot     (slot)
  );

  hdclk_slot_dec #(.CFG_W(CFG_W), .LANES(2)) u_dec (
    .slot      (slot),
    .span      (span),
    .half_bits (half_bits)
  );

  always_comb begin
    clk_p = half_bits[0];
    clk_n = half_bits[1];
  end
endmodule

// File: rtl/hdclk_chk.sv
module hdclk_chk #(
  parameter  int CFG_W  = 4,
  localparam int SLOT_W = CFG_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              adv,
  input logic [CFG_W-1:0]  phase_in,
  input logic              clk_p,
  input logic              clk_n,
  input logic [SLOT_W-1:0] slot,
  input logic [SLOT_W-1:0] span
);
  AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> ({1'b0, slot} < {span, 1'b0}));                        // R3

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !adv) |=> $stable({clk_p, clk_n}));                     // R4

  AST_IDLE_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (slot == SLOT_W'($past(phase_in))));                   // R5

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> $stable(span));                                         // R6
endmodule

bind hdclk_gen hdclk_chk #(.CFG_W(CFG_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .adv      (adv),
  .phase_in (phase_in),
  .clk_p    (clk_p),
  .clk_n    (clk_n),
  .slot     (slot),
  .span     (span)
);

// File: tb/hdclk_gen_test.sv
module hdclk_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       adv = 1'b0;
  logic [3:0] period_in = 4'd0;
  logic [3:0] phase_in = 4'd0;
  logic       clk_p;
  logic       clk_n;

  int n_chk = 0;
  int n_err = 0;

  logic [1:0] exp_q[$];
  string      tag_q[$];

  // Reference model state in half-slots.
  int   m_span = 16;
  int   m_ph = 0;
  int   m_s = 0;
  logic pv_en = 1'b0;
  logic pv_adv = 1'b0;
  int   pv_per = 0;
  int   pv_ph = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  hdclk_gen uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .adv       (adv),
    .period_in (period_in),
    .phase_in  (phase_in),
    .clk_p     (clk_p),
    .clk_n     (clk_n)
  );

  function automatic logic exp_bit(int s);
    return ((s + m_ph) % (2 * m_span)) >= m_span;
  endfunction

  // Driver: advance the model by one edge, drive inputs, queue the expectation.
  task automatic step(input logic e, input logic a, input int per, input int ph,
                      input string tag);
    @(posedge clk);
    if (!pv_en) begin
      m_span = (pv_per == 0) ? 16 : pv_per;
      m_ph   = pv_ph;
      m_s    = 0;
    end else if (pv_adv) begin
      m_s += 2;
    end
    #1;
    en = e; adv = a; period_in = per[3:0]; phase_in = ph[3:0];
    pv_en = e; pv_adv = a; pv_per = per; pv_ph = ph;
    exp_q.push_back({exp_bit(m_s + 1), exp_bit(m_s)});
    tag_q.push_back(tag);
  endtask

  // Monitor: compare mid-cycle.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if ({clk_n, clk_p} !== e) begin
        n_err++;
        $display("FAIL %s: {n,p} actual=%b expected=%b period=%0d phase=%0d slot=%0d",
                 t, {clk_n, clk_p}, e, m_span, m_ph, m_s);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;  // R1 reset state
    if ({clk_n, clk_p} !== 2'b00) begin
      n_err++;
      $display("FAIL R1: {n,p} actual=%b expected=00", {clk_n, clk_p});
    end
    rst_n = 1'b1;

    for (int d = 1; d <= 16; d++) begin
      for (int ph = 0; ph < 2 * d && ph < 16; ph++) begin
        int    code;
        string base;
        logic  prev_a;
        code   = d & 15;
        base   = (d == 16) ? "R2" : "R3";
        prev_a = 1'b1;
        step(1'b0, 1'b1, code, ph, "R5");
        step(1'b0, 1'b0, code, ph, "R5");
        step(1'b0, 1'b1, code, ph, "R5");
        for (int c = 0; c < 40; c++) begin
          logic  a;
          string tg;
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          a  = lfsr[0] | lfsr[1];
          tg = (c >= 20) ? "R6" : (!prev_a ? "R4" : base);
          if (c >= 20) step(1'b1, a, int'(lfsr[7:4]), int'(lfsr[11:8]), tg);
          else         step(1'b1, a, code, ph, tg);
          prev_a = a;
        end
      end
    end

    repeat (3) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule